// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the device side of a 4 Kbit serial EEPROM reached over an SPI bus in mode 0. The host drives a serial clock, serial data in, an active-low chip select, an active-low pause input and an active-low write-protect input. The block returns serial data out. All bus inputs are brought into the system clock domain through synchronizer chains and sampled there. The system clock must therefore run at least eight times faster than the serial clock.

Each chip-select frame starts with an 8-bit command. Read and write commands carry bit 8 of the address inside the opcode and take one more address byte. Write data is gathered into a page buffer. A self-timed programming cycle starts only when the frame ends on a whole byte and every protection check passes. During that cycle the buffered bytes are copied into a 512-byte register array, and the busy flag stays set for a parameterised number of clock cycles. Sequential reads stream bytes for as long as chip select stays low. The status byte reports busy, the write-enable latch and a two-bit protection level.

Top module: `ee_spi_eeprom`

## Requirements
- R1: After reset the serial output is 0, and a read-status command (0x05) returns 0x00. The status byte is {4'b0000, prot[1:0], wel, busy}, with busy in bit 0, wel in bit 1 and the protection level in bits 3:2.
- R2: Command 0x06 sets the write-enable latch (status bit 1). Command 0x04 clears it.
- R3: A write frame sent while the latch is clear changes no array byte and starts no busy cycle.
- R4: A write command 0000_A010 followed by an address byte stores its data at {A, address byte}. A read command 0000_A011 followed by an address byte returns the byte stored at that address. Both commands reach addresses at or above 0x100 through the A bit.
- R5: Write data that runs past the last byte of a 16-byte page continues at the first byte of the same page.
- R6: An accepted write raises busy at once, while the latch stays set. After PROG_CYCLES clock cycles, both busy and the latch read 0.
- R7: While busy, every command other than read-status is ignored. A write sent during the cycle leaves the array unchanged.
- R8: Write-status (0x01 plus a data byte) loads the protection level from data bits 3:2 and runs a busy cycle. Level 01 blocks writes to 0x180 and above, level 10 blocks writes to 0x100 and above, and level 11 blocks every write. A blocked write starts no cycle and leaves the latch set.
- R9: While the write-protect input is low, array writes and write-status are both refused, and neither starts a busy cycle.
- R10: A read keeps returning bytes at consecutive addresses while chip select stays low, and it wraps from 0x1FF to 0x000.
- R11: While the pause input is low, serial-clock and data-in transitions are ignored and the shift state and serial output are held. The transfer resumes correctly once the pause is released.
- R12: A write frame that ends with a partial byte starts no cycle and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host, mode 0 |
| si | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low pause |
| wp_n | input | 1 | Active-low write protect |
| so | output | 1 | Serial data to the host |

## Verification
A corrupted bit counter or command state shows up as a shifted or wrong byte on the serial output within the same frame. A wrong latch, busy or protection value is visible in the next read-status frame. A faulty page buffer or programming sequence appears only when the affected addresses are read back after the busy cycle ends. For that reason every write is followed by a read of the edge offsets of its page and of the bytes next to it.

// File: rtl/ee_pkg.sv
// Package: shared constants, command codes, state type and protection
// decode for the serial EEPROM controller.
package ee_pkg;
    localparam int ADDR_W = 9;                  // 512 bytes
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;

    typedef enum logic [2:0] {
        ST_CMD, ST_ADDR, ST_WDATA, ST_RDATA, ST_RDSR, ST_WRSR, ST_SKIP
    } fsm_t;

    // Read opcode: 0000_A011
    function automatic logic is_rd_op(input logic [7:0] b);
        return (b[7:4] == 4'h0) && (b[2:0] == 3'b011);
    endfunction

    // Write opcode: 0000_A010
    function automatic logic is_wr_op(input logic [7:0] b);
        return (b[7:4] == 4'h0) && (b[2:0] == 3'b010);
    endfunction

    // True when the quarter given by the top two address bits is protected
    function automatic logic quarter_locked(input logic [1:0] lvl, input logic [1:0] q);
        case (lvl)
            2'b00:   return 1'b0;
            2'b01:   return q == 2'b11;
            2'b10:   return q[1];
            default: return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/ee_spi_front.sv
// Module: ee_spi_front
// Brings the asynchronous bus pins into the clk domain through
// SYNC_STAGES flops each and flags serial-clock edges.
// Assumes clk is at least 8x the serial clock rate.
module ee_spi_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic si,
    input  logic cs_n,
    input  logic hold_n,
    input  logic wp_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s,
    output logic cs_s,
    output logic cs_rise,
    output logic hold_s,
    output logic wp_s
);
    localparam int NSIG = 5;
    localparam logic [NSIG-1:0] RST_VAL = 5'b11100;   // {cs, hold, wp, sck, si}

    logic [NSIG-1:0] pipe [SYNC_STAGES];
    logic            sck_d;
    logic            cs_d;

    // First synchronizer stage captures the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= RST_VAL;
        else        pipe[0] <= {cs_n, hold_n, wp_n, sck, si};
    end

    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
        // Further synchronizer stages
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[g] <= RST_VAL;
            else        pipe[g] <= pipe[g-1];
        end
    end

    // Delayed copies for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= pipe[SYNC_STAGES-1][1];
            cs_d  <= pipe[SYNC_STAGES-1][4];
        end
    end

    assign si_s     = pipe[SYNC_STAGES-1][0];
    assign wp_s     = pipe[SYNC_STAGES-1][2];
    assign hold_s   = pipe[SYNC_STAGES-1][3];
    assign cs_s     = pipe[SYNC_STAGES-1][4];
    assign sck_rise =  pipe[SYNC_STAGES-1][1] & ~sck_d;
    assign sck_fall = ~pipe[SYNC_STAGES-1][1] &  sck_d;
    assign cs_rise  =  cs_s & ~cs_d;
endmodule

// File: rtl/ee_prog_timer.sv
// Module: ee_prog_timer
// Self-timed programming cycle: busy for CYCLES clocks after start,
// stepping a page index through its first 2**PAGE_W cycles so that one
// buffered byte is copied per clock. Assumes CYCLES > 2**PAGE_W.
module ee_prog_timer #(
    parameter int CYCLES = 500000,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              copy_act,
    output logic [PAGE_W-1:0] copy_idx,
    output logic              done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt;

    // Down-counter and copy index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            copy_act <= 1'b0;
            copy_idx <= '0;
        end else if (start) begin
            cnt      <= LOAD;
            copy_act <= 1'b1;
            copy_idx <= '0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (copy_act) begin
                copy_idx <= copy_idx + 1'b1;
                if (&copy_idx) copy_act <= 1'b0;
            end
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));
endmodule

// File: rtl/ee_array.sv
// Module: ee_array
// 2**AW x 8 storage, one synchronous write port and one combinational
// read port; every byte resets to 0xFF (erased).
module ee_array #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // Erase on reset, write one byte when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ee_spi_eeprom.sv
// Module: ee_spi_eeprom (top)
// Command decoder, address and data shifting, page buffer, latch and
// protection state for a 512-byte SPI EEPROM in mode 0.
// Assumes the host keeps SCK low while changing CS.
module ee_spi_eeprom #(
    parameter int SYNC_STAGES = 2,
    parameter int PAGE_W      = 4,
    parameter int PROG_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic si,
    input  logic cs_n,
    input  logic hold_n,
    input  logic wp_n,
    output logic so
);
    import ee_pkg::*;

    localparam int AW  = ADDR_W;
    localparam int NPG = 1 << PAGE_W;
    localparam int PGA = AW - PAGE_W;

    logic sck_rise, sck_fall, si_s, cs_s, cs_rise, hold_s, wp_s;
    logic tmr_busy, tmr_act, tmr_done, start;
    logic [PAGE_W-1:0] tmr_idx;

    fsm_t              state;
    logic [2:0]        bit_cnt;
    logic [6:0]        sreg;
    logic [AW-1:0]     addr;
    logic              a8, wr_cmd, wel, have_data, prog_arr, so_r;
    logic [1:0]        prot, prot_new;
    logic [PGA-1:0]    ppage;
    logic [PAGE_W-1:0] woff;
    logic [7:0]        pbuf [NPG];
    logic [NPG-1:0]    pmask;
    logic [2:0]        bptr;

    logic       rise_g, fall_g, commit_ok, arr_we;
    logic [7:0] byte_in, rdata, sr_val;
    logic [1:0] page_q;

    ee_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n),
        .hold_n(hold_n), .wp_n(wp_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .si_s(si_s), .cs_s(cs_s), .cs_rise(cs_rise), .hold_s(hold_s), .wp_s(wp_s)
    );

    ee_prog_timer #(.CYCLES(PROG_CYCLES), .PAGE_W(PAGE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(tmr_busy),
        .copy_act(tmr_act), .copy_idx(tmr_idx), .done(tmr_done)
    );

    ee_array #(.AW(AW)) u_array (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr({ppage, tmr_idx}),
        .wdata(pbuf[tmr_idx]), .raddr(addr), .rdata(rdata)
    );

    assign rise_g  = sck_rise & hold_s & ~cs_s;
    assign fall_g  = sck_fall & hold_s & ~cs_s;
    assign byte_in = {sreg, si_s};
    assign sr_val  = {4'b0000, prot, wel, tmr_busy};
    assign page_q  = ppage[PGA-1 -: 2];
    assign arr_we  = tmr_act & prog_arr & pmask[tmr_idx];

    // Frame end check: whole bytes, latch set, pin released, region open
    always_comb begin
        commit_ok = wp_s && wel && !tmr_busy && (bit_cnt == 3'd0) && have_data &&
                    ((state == ST_WDATA && !quarter_locked(prot, page_q)) ||
                     state == ST_WRSR);
    end

    assign start = cs_rise & commit_ok;

    // Command, address, data and output shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_CMD;
            bit_cnt   <= '0;
            sreg      <= '0;
            addr      <= '0;
            a8        <= 1'b0;
            wr_cmd    <= 1'b0;
            wel       <= 1'b0;
            have_data <= 1'b0;
            prog_arr  <= 1'b0;
            prot      <= '0;
            prot_new  <= '0;
            ppage     <= '0;
            woff      <= '0;
            pmask     <= '0;
            bptr      <= 3'd7;
            so_r      <= 1'b0;
        end else begin
            if (cs_s) begin
                bit_cnt <= '0;
                state   <= ST_CMD;
                if (start) begin
                    prog_arr <= (state == ST_WDATA);
                    if (state == ST_WRSR) prot <= prot_new;
                end
            end else begin
                if (rise_g) begin
                    sreg    <= byte_in[6:0];
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == 3'd7) begin
                        case (state)
                            ST_CMD: begin
                                have_data <= 1'b0;
                                bptr      <= 3'd7;
                                if (tmr_busy && byte_in != OP_RDSR) state <= ST_SKIP;
                                else if (is_rd_op(byte_in)) begin
                                    a8 <= byte_in[3]; wr_cmd <= 1'b0; state <= ST_ADDR;
                                end else if (is_wr_op(byte_in)) begin
                                    a8 <= byte_in[3]; wr_cmd <= 1'b1; state <= ST_ADDR;
                                end else if (byte_in == OP_WREN) begin
                                    wel <= 1'b1; state <= ST_SKIP;
                                end else if (byte_in == OP_WRDI) begin
                                    wel <= 1'b0; state <= ST_SKIP;
                                end else if (byte_in == OP_RDSR) state <= ST_RDSR;
                                else if (byte_in == OP_WRSR) state <= ST_WRSR;
                                else state <= ST_SKIP;
                            end
                            ST_ADDR: begin
                                addr <= {a8, byte_in};
                                if (wr_cmd) begin
                                    ppage <= {a8, byte_in[7:PAGE_W]};
                                    woff  <= byte_in[PAGE_W-1:0];
                                    pmask <= '0;
                                    state <= ST_WDATA;
                                end else begin
                                    state <= ST_RDATA;
                                end
                            end
                            ST_WDATA: begin
                                pbuf[woff]  <= byte_in;
                                pmask[woff] <= 1'b1;
                                woff        <= woff + 1'b1;
                                have_data   <= 1'b1;
                            end
                            ST_WRSR: begin
                                prot_new  <= byte_in[3:2];
                                have_data <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                if (fall_g && (state == ST_RDATA || state == ST_RDSR)) begin
                    so_r <= (state == ST_RDATA) ? rdata[bptr] : sr_val[bptr];
                    bptr <= bptr - 1'b1;
                    if (bptr == 3'd0 && state == ST_RDATA) addr <= addr + 1'b1;
                end
            end
            if (tmr_done) wel <= 1'b0;
        end
    end

    assign so = so_r;
endmodule

// File: rtl/ee_spi_eeprom_chk.sv
// Module: ee_spi_eeprom_chk
// Property checker bound into ee_spi_eeprom; observes only.
module ee_spi_eeprom_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       wel,
    input logic       wp_s,
    input logic       hold_s,
    input logic       cs_s,
    input logic [2:0] bit_cnt,
    input logic       so,
    input logic       prog_arr,
    input logic [1:0] page_q,
    input logic [1:0] prot,
    input logic       arr_we
);
    // R6: latch is clear once the cycle ends
    p_wel_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    // R3: a cycle only starts with the latch set
    p_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));

    // R9: a cycle only starts with write protect released
    p_wp_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wp_s));

    // R8: an array cycle never targets a protected quarter
    p_prot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && prog_arr) |->
        !((prot == 2'b11) || (prot == 2'b10 && page_q[1]) ||
          (prot == 2'b01 && page_q == 2'b11)));

    // R6: array bytes change only during a busy cycle
    p_write_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R11: paused frames hold bit count and output
    p_hold_cnt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_s && !cs_s) |=> (cs_s || $stable(bit_cnt)));

    p_hold_so_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_s |=> $stable(so));
endmodule

bind ee_spi_eeprom ee_spi_eeprom_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(tmr_busy), .wel(wel), .wp_s(wp_s),
    .hold_s(hold_s), .cs_s(cs_s), .bit_cnt(bit_cnt), .so(so_r),
    .prog_arr(prog_arr), .page_q(page_q), .prot(prot), .arr_we(arr_we)
);

// File: tb/ee_spi_eeprom_test.sv
// Bench: ee_spi_eeprom_test. Scoreboard style: frame tasks queue expected
// bytes with their requirement tag, a monitor compares captured bytes.
module ee_spi_eeprom_test;
    localparam int PROG = 2000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, si = 1'b0, cs_n = 1'b1, hold_n = 1'b1, wp_n = 1'b1;
    logic so;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] got_q [$];
    int vectors = 0, miscompares = 0;
    bit finished = 0;

    ee_spi_eeprom #(.SYNC_STAGES(2), .PAGE_W(4), .PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n),
        .hold_n(hold_n), .wp_n(wp_n), .so(so)
    );

    always #5 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_b(input logic [7:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    // One byte, MSB first; optional pause after the given bit
    task automatic xfer(input logic [7:0] mo, input int hold_at, output logic [7:0] mi);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; si = mo[i];
            tick(8);
            mi[i] = so;
            sck = 1'b1;
            tick(8);
            if (i == hold_at) begin
                hold_n = 1'b0;
                tick(4);
                for (int k = 0; k < 3; k++) begin
                    sck = 1'b0; si = ~si; tick(6);
                    sck = 1'b1; tick(6);
                end
                tick(4);
                hold_n = 1'b1;
                tick(4);
            end
        end
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] d;
        xfer(b, -1, d);
    endtask

    task automatic cs_lo();
        tick(4); cs_n = 1'b0; tick(8);
    endtask

    task automatic cs_hi();
        sck = 1'b0; tick(8); cs_n = 1'b1; tick(16);
    endtask

    task automatic cmd1(input logic [7:0] op);
        cs_lo(); send(op); cs_hi();
    endtask

    task automatic rdsr(input logic [7:0] e, input string t);
        logic [7:0] r;
        expect_b(e, t);
        cs_lo(); send(8'h05); xfer(8'h00, -1, r); got_q.push_back(r); cs_hi();
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d[8], input int n, input int hold_at);
        logic [7:0] r;
        cs_lo();
        send({4'h0, a[8], 3'b010});
        send(a[7:0]);
        for (int i = 0; i < n; i++) xfer(d[i], (i == 0) ? hold_at : -1, r);
        cs_hi();
    endtask

    task automatic rd(input logic [8:0] a, input logic [7:0] e[8], input int n,
                      input int hold_at, input string t);
        logic [7:0] r;
        cs_lo();
        send({4'h0, a[8], 3'b011});
        send(a[7:0]);
        for (int i = 0; i < n; i++) begin
            expect_b(e[i], t);
            xfer(8'h00, (i == 0) ? hold_at : -1, r);
            got_q.push_back(r);
        end
        cs_hi();
    endtask

    task automatic wr1(input logic [8:0] a, input logic [7:0] v);
        logic [7:0] d[8];
        d = '{default: 8'h00};
        d[0] = v;
        wr(a, d, 1, -1);
    endtask

    task automatic rd1(input logic [8:0] a, input logic [7:0] v, input string t);
        logic [7:0] e[8];
        e = '{default: 8'h00};
        e[0] = v;
        rd(a, e, 1, -1, t);
    endtask

    // Monitor: compare captured bytes against the expected queue
    initial begin
        forever begin
            logic [7:0] g, e;
            string t;
            wait (got_q.size() > 0);
            g = got_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vectors++;
            if (g !== e) begin
                miscompares++;
                $display("FAIL %s: got %02h expected %02h", t, g, e);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Stimulus
    initial begin
        logic [7:0] d[8];
        logic [7:0] e[8];
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: reset state
        expect_b(8'h00, "R1 so reset");
        got_q.push_back({7'b0, so});
        rdsr(8'h00, "R1 status reset");

        // R3: write without latch
        wr1(9'h010, 8'hAA);
        rdsr(8'h00, "R3 no busy");
        rd1(9'h010, 8'hFF, "R3 unchanged");

        // R2: latch set and clear
        cmd1(8'h06);
        rdsr(8'h02, "R2 wel set");
        cmd1(8'h04);
        rdsr(8'h00, "R2 wel clear");

        // R4 R5 R6: page write with wrap in the upper half
        cmd1(8'h06);
        d = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h00, 8'h00};
        wr(9'h1FC, d, 6, -1);
        rdsr(8'h03, "R6 busy and wel");
        // R7: write during busy is ignored
        wr1(9'h000, 8'h77);
        tick(PROG + 100);
        rdsr(8'h00, "R6 busy and wel end");

        // R10: sequential read wraps 0x1FF -> 0x000; R7 byte at 0 untouched
        e = '{8'h33, 8'h44, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        rd(9'h1FE, e, 3, -1, "R10 R7 wrap read");
        // R5: wrapped bytes at page start, next byte untouched
        e = '{8'h55, 8'h66, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        rd(9'h1F0, e, 3, -1, "R5 page wrap");

        // R4: low-half address
        cmd1(8'h06);
        wr1(9'h000, 8'h5A);
        tick(PROG + 100);
        rd1(9'h000, 8'h5A, "R4 low write");

        // R11: pause during write and read
        cmd1(8'h06);
        d = '{8'hC3, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        wr(9'h020, d, 2, 3);
        tick(PROG + 100);
        e = '{8'hC3, 8'h3C, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        rd(9'h020, e, 3, 4, "R11 pause");

        // R12: partial trailing byte
        cmd1(8'h06);
        cs_lo();
        send(8'h02); send(8'h30); send(8'h99);
        for (int i = 0; i < 4; i++) begin
            sck = 1'b0; si = 1'b1; tick(8); sck = 1'b1; tick(8);
        end
        cs_hi();
        rdsr(8'h02, "R12 no cycle");
        rd1(9'h030, 8'hFF, "R12 nothing stored");

        // R8: protect upper quarter
        cs_lo(); send(8'h01); send(8'h04); cs_hi();
        rdsr(8'h07, "R8 status write busy");
        tick(PROG + 100);
        rdsr(8'h04, "R8 level kept");
        cmd1(8'h06);
        wr1(9'h180, 8'h12);
        rdsr(8'h06, "R8 blocked no cycle");
        rd1(9'h180, 8'hFF, "R8 blocked data");
        wr1(9'h100, 8'h34);
        tick(PROG + 100);
        rd1(9'h100, 8'h34, "R8 open quarter");

        // R9: write-protect pin
        wp_n = 1'b0;
        cmd1(8'h06);
        wr1(9'h040, 8'h56);
        rdsr(8'h06, "R9 no cycle");
        rd1(9'h040, 8'hFF, "R9 data");
        cs_lo(); send(8'h01); send(8'h00); cs_hi();
        rdsr(8'h06, "R9 status kept");
        wp_n = 1'b1;

        wait (got_q.size() == 0);
        tick(4);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule